// File: doc/BRIEF.md
# Eight-Bar Video Pattern Generator

This block produces an endless sequence of video frames filled with vertical test bars. Each output beat carries several adjacent pixels. A mode input selects one of four bar variants: colour bars, a descending greyscale ramp, alternating black and white, or a mixed frame that stacks those three variants vertically. The block has no gaps of its own. Once reset is over it always holds a beat, and the downstream sink sets the pace through a ready/valid handshake.

The line width and frame height, the colour space, 4:2:2 horizontal subsampling and the mode are taken from inputs. The block samples them only at a frame boundary, so the upstream logic can change them at any time. The bits per sample and the pixels per beat are parameters. Each bar colour is defined as an 8-bit level. For wider samples that level is moved up into the most significant bits and the low bits are filled with zeros. The first beat of each frame and the last beat of each line carry marker outputs.

Top module: `bars_pattern_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `valid_o` is low. From the next cycle on it is high and stays high. That first beat is the first beat of a frame.
- R2: Without subsampling, take a line width W. The leftmost bar is floor(W/8) pixels wide. Bars 1 up to W%8 are each one pixel wider than that, and the remaining bars have the leftmost width.
- R3: No bar is narrower than the minimum width M. M is `PPB`, or 2 under 4:2:2 when `PPB` is 1. If the rule in R2 (or in R4) gives bars narrower than M, every bar is M pixels wide, and only W/M bars appear.
- R4: With `sub422_i`=1 the rule in R2 is applied to pixel pairs. Bars 1 up to (W/2)%8 get one extra pair, so every bar width is even.
- R5: Each pixel is 3·BPS bits, with component 0 in the low bits. In RGB, components 0, 1 and 2 are R, G and B. In YCbCr they are Y, Cb and Cr. The colour bar levels, from left to right, are RGB (180,180,180), (180,180,16), (16,180,180), (16,180,16), (180,16,180), (180,16,16), (16,16,180), (16,16,16). The YCbCr levels in (Y,Cb,Cr) order are (180,128,128), (162,44,142), (131,156,44), (112,72,58), (84,184,198), (65,100,212), (35,212,114), (16,128,128). Each level is shifted left by BPS-8.
- R6: Under 4:2:2, YCbCr levels are used whatever `ycbcr_i` says. Component 0 is Y. Component 1 is Cb at even x and Cr at odd x. Component 2 is zero.
- R7: The mode encoding is 0 = colour, 1 = greyscale, 2 = black/white, 3 = mixed. The greyscale luma runs 180, 162, 131, 112, 84, 65, 35, 16. Black/white alternates 180 and 16, starting with 180 at the left. Chroma is 128 in YCbCr, and R=G=B=luma in RGB.
- R8: In mixed mode, take h = floor(H/8). Rows below h are black/white, rows h to 2h-1 are greyscale, and the remaining rows are colour bars.
- R9: Beats run left to right and top to bottom. Lane p holds pixel x+p. `sof_o` marks the first beat of a frame. `eol_o` marks the last beat of each line.
- R10: Mode, width, height, colour space and subsampling are sampled only when a frame starts. A change in the middle of a frame leaves that frame untouched and applies to the next frame.
- R11: While `valid_o` is high and `ready_i` is low, `data_o`, `sof_o` and `eol_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bar variant select (R7) |
| width_i | input | WW | Line width in pixels; a multiple of PPB and, under 4:2:2, of 2 |
| height_i | input | HW | Frame height in lines, at least 1 |
| ycbcr_i | input | 1 | 1 = YCbCr levels, 0 = RGB |
| sub422_i | input | 1 | 1 = 4:2:2 output |
| ready_i | input | 1 | Sink accepts the current beat |
| valid_o | output | 1 | Beat available |
| sof_o | output | 1 | First beat of a frame |
| eol_o | output | 1 | Last beat of a line |
| data_o | output | PPB*3*BPS | Pixels of the beat, lane 0 in the low bits |

## Verification
The beat counters and the latched settings are registers, and the pixel values are decoded from them with combinational logic only. So a beat's data, `sof_o` and `eol_o` are valid for the whole cycle before the clock edge that takes it with `ready_i`. The next beat appears right after that edge. The bench sets `ready_i` and samples the outputs at the falling edge, and it counts a beat only when valid and ready were both high at that point. A new setting applies from the first frame that starts after the end of the frame that was running when the setting was applied. The bench therefore lets that frame go by before it compares the next one, and it checks a mid-frame change against the old values until that frame's last beat.

// File: rtl/bargen_pkg.sv
package bargen_pkg;

    typedef enum logic [1:0] {
        BAR_COLOUR = 2'd0,
        BAR_GREY   = 2'd1,
        BAR_BW     = 2'd2,
        BAR_MIXED  = 2'd3
    } bar_mode_e;

    // {B, G, R} at 8 bits
    function automatic logic [23:0] colour_rgb(input logic [2:0] idx);
        case (idx)
            3'd0:    return {8'd180, 8'd180, 8'd180};
            3'd1:    return {8'd16,  8'd180, 8'd180};
            3'd2:    return {8'd180, 8'd180, 8'd16};
            3'd3:    return {8'd16,  8'd180, 8'd16};
            3'd4:    return {8'd180, 8'd16,  8'd180};
            3'd5:    return {8'd16,  8'd16,  8'd180};
            3'd6:    return {8'd180, 8'd16,  8'd16};
            default: return {8'd16,  8'd16,  8'd16};
        endcase
    endfunction

    // {Cr, Cb, Y} at 8 bits
    function automatic logic [23:0] colour_ycc(input logic [2:0] idx);
        case (idx)
            3'd0:    return {8'd128, 8'd128, 8'd180};
            3'd1:    return {8'd142, 8'd44,  8'd162};
            3'd2:    return {8'd44,  8'd156, 8'd131};
            3'd3:    return {8'd58,  8'd72,  8'd112};
            3'd4:    return {8'd198, 8'd184, 8'd84};
            3'd5:    return {8'd212, 8'd100, 8'd65};
            3'd6:    return {8'd114, 8'd212, 8'd35};
            default: return {8'd128, 8'd128, 8'd16};
        endcase
    endfunction

    function automatic logic [7:0] grey_luma(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'd180;
            3'd1:    return 8'd162;
            3'd2:    return 8'd131;
            3'd3:    return 8'd112;
            3'd4:    return 8'd84;
            3'd5:    return 8'd65;
            3'd6:    return 8'd35;
            default: return 8'd16;
        endcase
    endfunction

endpackage

// File: rtl/bargen_bounds.sv
// Start column of bars 1..7 for a given line width.
module bargen_bounds #(
    parameter int PPB = 2,
    parameter int WW  = 13
) (
    input  logic                 sub422_i,
    input  logic [WW-1:0]        width_i,
    output logic [6:0][WW-1:0]   bounds_o
);
    logic [WW-1:0] units;
    logic [WW-1:0] base;
    logic [2:0]    spare;
    logic [WW-1:0] min_w;
    logic          narrow;

    always_comb begin
        units  = sub422_i ? (width_i >> 1) : width_i;
        base   = units >> 3;
        spare  = units[2:0];
        if (PPB >= 2) min_w = WW'(PPB);
        else          min_w = sub422_i ? WW'(2) : WW'(1);
        narrow = ((base << sub422_i) < min_w);
    end

    for (genvar k = 1; k <= 7; k++) begin : g_bound
        logic [WW-1:0] extra;
        always_comb begin
            extra = (3'(k - 1) < spare) ? WW'(k - 1) : WW'(spare);
            if (narrow) bounds_o[k-1] = WW'(k) * min_w;
            else        bounds_o[k-1] = (WW'(k) * base + extra) << sub422_i;
        end
    end
endmodule

// File: rtl/bargen_lane.sv
// Colour of one pixel lane.
module bargen_lane
    import bargen_pkg::*;
#(
    parameter int BPS = 10,
    parameter int WW  = 13
) (
    input  logic [WW-1:0]        x_i,
    input  logic [6:0][WW-1:0]   bounds_i,
    input  bar_mode_e            variant_i,
    input  logic                 yuv_i,
    input  logic                 sub422_i,
    output logic [3*BPS-1:0]     pix_o
);
    localparam int SH = BPS - 8;

    logic [2:0]  bar;
    logic [23:0] v8;
    logic [7:0]  luma;
    logic [7:0]  c0, c1, c2;
    logic        use_yuv;

    always_comb begin
        bar = 3'd0;
        for (int k = 0; k < 7; k++) begin
            if (x_i >= bounds_i[k]) bar = bar + 3'd1;
        end
    end

    always_comb begin
        use_yuv = yuv_i | sub422_i;
        luma    = 8'd0;
        case (variant_i)
            BAR_GREY: begin
                luma = grey_luma(bar);
                v8   = use_yuv ? {8'd128, 8'd128, luma} : {luma, luma, luma};
            end
            BAR_BW: begin
                luma = bar[0] ? 8'd16 : 8'd180;
                v8   = use_yuv ? {8'd128, 8'd128, luma} : {luma, luma, luma};
            end
            default: v8 = use_yuv ? colour_ycc(bar) : colour_rgb(bar);
        endcase
        c0 = v8[7:0];
        if (sub422_i) begin
            c1 = x_i[0] ? v8[23:16] : v8[15:8];
            c2 = 8'd0;
        end else begin
            c1 = v8[15:8];
            c2 = v8[23:16];
        end
        pix_o = {BPS'(c2) << SH, BPS'(c1) << SH, BPS'(c0) << SH};
    end
endmodule

// File: rtl/bars_pattern_gen.sv
module bars_pattern_gen
    import bargen_pkg::*;
#(
    parameter int PPB   = 2,
    parameter int BPS   = 10,
    parameter int MAX_W = 4096,
    parameter int MAX_H = 4096,
    localparam int WW   = $clog2(MAX_W + 1),
    localparam int HW   = $clog2(MAX_H + 1),
    localparam int PIXW = 3 * BPS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode_i,
    input  logic [WW-1:0]       width_i,
    input  logic [HW-1:0]       height_i,
    input  logic                ycbcr_i,
    input  logic                sub422_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic                sof_o,
    output logic                eol_o,
    output logic [PPB*PIXW-1:0] data_o
);
    typedef struct packed {
        logic                valid;
        logic [WW-1:0]       x;
        logic [HW-1:0]       y;
        logic [1:0]          mode;
        logic [WW-1:0]       width;
        logic [HW-1:0]       height;
        logic                yuv;
        logic                s422;
        logic [6:0][WW-1:0]  bounds;
    } gen_state_t;

    gen_state_t          st_d, st_q;
    logic [6:0][WW-1:0]  bounds_w;
    logic [WW:0]         x_next;
    logic                line_end;
    logic                last_row_w;
    logic                load;
    logic [HW-1:0]       h8;
    bar_mode_e           variant;

    bargen_bounds #(.PPB(PPB), .WW(WW)) u_bounds (
        .sub422_i (sub422_i),
        .width_i  (width_i),
        .bounds_o (bounds_w)
    );

    always_comb begin
        x_next     = {1'b0, st_q.x} + (WW+1)'(PPB);
        line_end   = (x_next >= {1'b0, st_q.width});
        last_row_w = (st_q.y == st_q.height - HW'(1));
        load       = 1'b0;
        st_d       = st_q;
        if (!st_q.valid) begin
            st_d.valid = 1'b1;
            load       = 1'b1;
        end else if (ready_i) begin
            if (line_end) begin
                st_d.x = '0;
                if (last_row_w) load = 1'b1;
                else            st_d.y = st_q.y + HW'(1);
            end else begin
                st_d.x = x_next[WW-1:0];
            end
        end
        if (load) begin
            st_d.x      = '0;
            st_d.y      = '0;
            st_d.mode   = mode_i;
            st_d.width  = width_i;
            st_d.height = height_i;
            st_d.yuv    = ycbcr_i;
            st_d.s422   = sub422_i;
            st_d.bounds = bounds_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        h8 = st_q.height >> 3;
        if (bar_mode_e'(st_q.mode) != BAR_MIXED) variant = bar_mode_e'(st_q.mode);
        else if (st_q.y < h8)                    variant = BAR_BW;
        else if (st_q.y < (h8 << 1))             variant = BAR_GREY;
        else                                     variant = BAR_COLOUR;
    end

    for (genvar p = 0; p < PPB; p++) begin : g_lane
        bargen_lane #(.BPS(BPS), .WW(WW)) u_lane (
            .x_i       (st_q.x + WW'(p)),
            .bounds_i  (st_q.bounds),
            .variant_i (variant),
            .yuv_i     (st_q.yuv),
            .sub422_i  (st_q.s422),
            .pix_o     (data_o[p*PIXW +: PIXW])
        );
    end

    assign valid_o = st_q.valid;
    assign sof_o   = st_q.valid && (st_q.x == '0) && (st_q.y == '0);
    assign eol_o   = st_q.valid && line_end;
endmodule

// File: rtl/bars_pattern_gen_chk.sv
module bars_pattern_gen_chk #(
    parameter int DW = 60,
    parameter int WW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid,
    input logic          ready,
    input logic          sof,
    input logic          eol,
    input logic [DW-1:0] data,
    input logic [1:0]    cfg_mode,
    input logic [WW-1:0] cfg_width,
    input logic          last_row
);
    // R1: once beats start they never stop
    p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

    // R11: a stalled beat is held
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> ($stable(data) && $stable(sof) && $stable(eol)));

    // R9: a frame start only follows a line end
    p_sof_after_eol_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !eol) |=> !sof);

    // R10: frame settings frozen until the last beat of the frame goes out
    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !(ready && eol && last_row)) |=> ($stable(cfg_mode) && $stable(cfg_width)));
endmodule

bind bars_pattern_gen bars_pattern_gen_chk #(.DW(PPB*3*BPS), .WW(WW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid_o),
    .ready     (ready_i),
    .sof       (sof_o),
    .eol       (eol_o),
    .data      (data_o),
    .cfg_mode  (st_q.mode),
    .cfg_width (st_q.width),
    .last_row  (last_row_w)
);

// File: tb/bars_pattern_gen_test.sv
module bars_pattern_gen_test;
    localparam int PPB = 2;
    localparam int BPS = 10;
    localparam int WW  = 13;
    localparam int HW  = 13;
    localparam int PIXW = 3 * BPS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [WW-1:0] width_i = WW'(64);
    logic [HW-1:0] height_i = HW'(4);
    logic ycbcr_i = 1'b0;
    logic sub422_i = 1'b0;
    logic ready_i = 1'b1;
    logic valid_o, sof_o, eol_o;
    logic [PPB*PIXW-1:0] data_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bars_pattern_gen #(.PPB(PPB), .BPS(BPS)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .width_i(width_i),
        .height_i(height_i), .ycbcr_i(ycbcr_i), .sub422_i(sub422_i),
        .ready_i(ready_i), .valid_o(valid_o), .sof_o(sof_o), .eol_o(eol_o),
        .data_o(data_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 60000) begin
            fails++;
            $display("FAIL watchdog: act %0d cycles exp < 60000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act %h exp %h", tag, act, exp);
        end
    endtask

    // model tables in (c0,c1,c2) = (R,G,B) or (Y,Cb,Cr)
    function automatic int tb_col(int b, bit yuv, int comp);
        int rgb [8][3] = '{'{180,180,180},'{180,180,16},'{16,180,180},'{16,180,16},
                           '{180,16,180},'{180,16,16},'{16,16,180},'{16,16,16}};
        int ycc [8][3] = '{'{180,128,128},'{162,44,142},'{131,156,44},'{112,72,58},
                           '{84,184,198},'{65,100,212},'{35,212,114},'{16,128,128}};
        return yuv ? ycc[b][comp] : rgb[b][comp];
    endfunction

    function automatic int tb_bar(int x, int w, bit s);
        int unit = s ? 2 : 1;
        int base = (w / unit) / 8;
        int rem  = (w / unit) % 8;
        int minw = (PPB >= 2) ? PPB : unit;
        int acc  = 0;
        if (base * unit < minw) return x / minw;
        for (int i = 0; i < 8; i++) begin
            int bw = unit * (base + ((i >= 1 && i <= rem) ? 1 : 0));
            if (x < acc + bw) return i;
            acc += bw;
        end
        return 7;
    endfunction

    function automatic logic [PIXW-1:0] tb_pix(int x, int y, int w, int h, int mode, bit yuv, bit s);
        int grey [8] = '{180,162,131,112,84,65,35,16};
        int v = mode;
        int b, c0, c1, c2;
        bit uy = yuv | s;
        if (mode == 3) v = (y < h / 8) ? 2 : ((y < 2 * (h / 8)) ? 1 : 0);
        b = tb_bar(x, w, s);
        if (v == 0) begin
            c0 = tb_col(b, uy, 0); c1 = tb_col(b, uy, 1); c2 = tb_col(b, uy, 2);
        end else begin
            c0 = (v == 1) ? grey[b] : ((b % 2 == 0) ? 180 : 16);
            c1 = uy ? 128 : c0;
            c2 = uy ? 128 : c0;
        end
        if (s) begin
            c1 = (x % 2 == 1) ? c2 : c1;
            c2 = 0;
        end
        return {BPS'(c2 << (BPS - 8)), BPS'(c1 << (BPS - 8)), BPS'(c0 << (BPS - 8))};
    endfunction

    task automatic apply(int w, int h, int mode, bit yuv, bit s);
        width_i = WW'(w); height_i = HW'(h); mode_i = 2'(mode);
        ycbcr_i = yuv; sub422_i = s;
    endtask

    // wait until the next frame certainly uses the settings applied now
    task automatic goto_fresh(int w, int h, int mode, bit yuv, bit s);
        apply(w, h, mode, yuv, s);
        ready_i = 1'b1;
        while (!(valid_o && sof_o)) @(negedge clk);
        @(negedge clk);
        while (!(valid_o && sof_o)) @(negedge clk);
    endtask

    // captures one frame starting at the current negedge
    task automatic capture(string tag, int w, int h, int mode, bit yuv, bit s, bit stall,
                           int chg_beat, int nw, int nh, int nmode, bit nyuv, bit ns);
        int bpl = w / PPB;
        int nb = bpl * h;
        int cyc = 0;
        for (int b = 0; b < nb; ) begin
            int x = (b % bpl) * PPB;
            int y = b / bpl;
            logic [PPB*PIXW-1:0] exp;
            if (b == chg_beat) apply(nw, nh, nmode, nyuv, ns);
            for (int p = 0; p < PPB; p++) exp[p*PIXW +: PIXW] = tb_pix(x + p, y, w, h, mode, yuv, s);
            ready_i = stall ? ((cyc % 3) != 2) : 1'b1;
            cyc++;
            if (ready_i) begin
                check(tag, {valid_o, sof_o, eol_o, data_o},
                      {1'b1, (b == 0), (x + PPB >= w), exp});
                b++;
            end else begin
                check({tag, " R11 stall"}, {valid_o, data_o}, {1'b1, exp});
            end
            @(negedge clk);
        end
        ready_i = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", valid_o, 1'b0);
        rst_n = 1'b1;
        check("R1 first cycle", valid_o, 1'b0);
        @(negedge clk);
        check("R1 R9 first beat", {valid_o, sof_o}, 2'b11);
    endtask

    task automatic t_colour_rgb();
        goto_fresh(64, 4, 0, 0, 0);
        capture("R2 R5 R9 colour rgb", 64, 4, 0, 0, 0, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_colour_ycc_rem();
        goto_fresh(70, 3, 0, 1, 0);
        capture("R2 R5 colour ycc w70", 70, 3, 0, 1, 0, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_narrow();
        goto_fresh(12, 2, 1, 0, 0);
        capture("R3 R7 grey narrow", 12, 2, 1, 0, 0, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_bw_422();
        goto_fresh(44, 2, 2, 0, 1);
        capture("R4 R6 R7 bw 422", 44, 2, 2, 0, 1, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_colour_422();
        goto_fresh(40, 2, 0, 1, 1);
        capture("R6 colour 422", 40, 2, 0, 1, 1, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mixed();
        goto_fresh(32, 16, 3, 0, 0);
        capture("R8 mixed rgb", 32, 16, 3, 0, 0, 0, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_mixed_stall();
        goto_fresh(32, 20, 3, 1, 0);
        capture("R8 R11 mixed ycc stall", 32, 20, 3, 1, 0, 1, -1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_midframe();
        goto_fresh(32, 4, 0, 0, 0);
        capture("R10 old frame kept", 32, 4, 0, 0, 0, 0, 20, 48, 2, 1, 1, 0);
        capture("R10 next frame new", 48, 2, 1, 1, 0, 0, -1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_colour_rgb();
        t_colour_ycc_rem();
        t_narrow();
        t_bw_422();
        t_colour_422();
        t_mixed();
        t_mixed_stall();
        t_midframe();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule